// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a bank of flops that re-times the command and address lines of a memory module. Every input is captured on the rising edge of `clk` and appears at the outputs one cycle later. A static strap (`pair_mode`) sets the bank's shape. It can run as 25 single-fanout lanes. It can also run as 14 lanes, each driving an A copy and a B copy of the same bit. A second strap (`map_sel`) chooses which lane positions the paired shape uses.

The ordinary data lanes are gated by two active-low selects. When both selects are high, the data outputs keep their last value. The registered chip-select, termination-control and clock-enable bits are never gated. They follow their inputs on every edge.

An active-low reset clears every register and forces every output low at once, with no wait for a clock edge. Release passes through a two-stage synchronizer, so outputs stay low until the first clean capture. The straps are meant to change only while reset is held.

Top module: `rcb_cmd_buffer`

## Requirements
- R1: In single-fanout mode (`pair_mode`=0), `q_a[i]` equals `d_in[i]` as sampled at the previous rising edge of `clk`, for every i in 0..24.
- R2: In single-fanout mode, all 14 bits of `q_b` are held at 0.
- R3: In paired mode with the low map (`pair_mode`=1, `map_sel`=0), lane k (0..13) takes `d_in[k]` and drives both `q_a[k]` and `q_b[k]`. `q_a[14..24]` stay 0.
- R4: In paired mode with the high map (`pair_mode`=1, `map_sel`=1), lane k (0..13) takes `d_in[11+k]` and drives both `q_a[11+k]` and `q_b[k]`. `q_a[0..10]` stay 0.
- R5: When `cs_n` and `cs2_n` are both 1 at a rising edge, `q_a` and `q_b` keep their previous values.
- R6: When either `cs_n` or `cs2_n` is 0 at a rising edge, `q_a` and `q_b` load the mapped data. Holding `cs2_n` at 0 therefore makes the data update on every edge.
- R7: `cs_n_q`, `odt_q` and `cke_q` load `cs_n`, `odt_in` and `cke_in` on every rising edge, whatever the selects are.
- R8: While `rst_n` is 0, every output is 0. This takes effect within the cycle in which reset asserts and overrides the selects.
- R9: After `rst_n` rises, the first two rising edges leave every output at 0. The third rising edge performs the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases through a synchronizer |
| pair_mode | input | 1 | Strap: 0 = 25 single-fanout lanes, 1 = 14 paired lanes |
| map_sel | input | 1 | Strap: paired-mode lane map, 0 = low positions, 1 = high positions |
| cs_n | input | 1 | Data chip select, active low; also registered to `cs_n_q` |
| cs2_n | input | 1 | Secondary select, active low; tie to 0 to disable gating |
| cke_in | input | 1 | Clock-enable bit, never gated |
| odt_in | input | 1 | Termination-control bit, never gated |
| d_in | input | 25 | Data/address inputs |
| q_a | output | 25 | Registered data outputs, A side |
| q_b | output | 14 | Registered data outputs, B side (paired mode only) |
| cs_n_q | output | 1 | Registered chip select |
| cke_q | output | 1 | Registered clock enable |
| odt_q | output | 1 | Registered termination control |

## Verification
The bench builds the block with its default 25-lane, 14-pair shape and a two-stage release synchronizer. It runs the full sequence once for each of the three strap settings. Each run drives 64 arithmetically generated data words while cycling through all four select combinations, so both hold and update are seen in every lane map. That coverage also includes the case where only the secondary select is low. A mid-cycle reset is applied in every strap setting. After it, the bench checks the immediate clear and then counts the exact edge of the first capture after release.

// File: rtl/rcb_pkg.sv
`timescale 1ns/1ps
// Package: shared types and lane-map helpers for the registered command buffer.
// Assumes lane maps are decided by static straps that only move under reset.
package rcb_pkg;

    // Paired-mode lane map: which positions of the wide bank are used.
    typedef enum logic {
        MAP_LOW  = 1'b0,
        MAP_HIGH = 1'b1
    } map_e;

    // Returns 1 when wide lane idx is live for the given strap settings.
    function automatic logic lane_live(input int idx, input int n_wide, input int n_pair,
                                       input logic pair, input map_e map);
        if (!pair) return 1'b1;
        if (map == MAP_HIGH) return (idx >= (n_wide - n_pair));
        return (idx < n_pair);
    endfunction

endpackage

// File: rtl/rcb_reset_sync.sv
`timescale 1ns/1ps
// Module: rcb_reset_sync
// Clears its output as soon as the raw reset asserts and releases it only after
// STAGES rising edges with the raw reset high. Assumes the raw reset may
// change at any point relative to clk.
module rcb_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain;

    // Shift ones in after release; clear the whole chain at once on assertion.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_sync_n = chain[STAGES-1];

    // R9: the internal release can only rise after the raw reset was high at an edge.
    a_r9_release_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_sync_n) |-> $past(rst_n))
        else $error("R9 internal release without raw release");
endmodule

// File: rtl/rcb_ctrl_regs.sv
`timescale 1ns/1ps
// Module: rcb_ctrl_regs
// Registers the ungated control bits: chip select, termination control and
// clock enable. They load on every edge no matter what the selects are.
// Assumes rst_n asserts asynchronously and releases synchronously.
module rcb_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic odt_in,
    input  logic cke_in,
    output logic cs_n_q,
    output logic odt_q,
    output logic cke_q
);
    logic armed;

    // Capture the three control bits unconditionally.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= 1'b0;
            odt_q  <= 1'b0;
            cke_q  <= 1'b0;
        end else begin
            cs_n_q <= cs_n;
            odt_q  <= odt_in;
            cke_q  <= cke_in;
        end
    end

    // Marks that at least one real capture has happened since reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R7: each control output reflects its input from the previous edge.
    a_r7_ctrl_always_loads: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ({cs_n_q, odt_q, cke_q} == $past({cs_n, odt_in, cke_in})))
        else $error("R7 control bit did not follow its input");
endmodule

// File: rtl/rcb_lane_bank.sv
`timescale 1ns/1ps
// Module: rcb_lane_bank
// The gated data bank. The wide A-side lanes load their input when live and
// zero otherwise. The B-side lanes copy the paired source in paired mode and
// zero in single mode. All lanes hold when the hold input is high.
// Assumes pair_mode and map_sel are static outside reset.
module rcb_lane_bank
    import rcb_pkg::*;
#(
    parameter int NUM_WIDE = 25,
    parameter int NUM_PAIR = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pair_mode,
    input  map_e                map_sel,
    input  logic                hold,
    input  logic [NUM_WIDE-1:0] d_in,
    output logic [NUM_WIDE-1:0] q_a,
    output logic [NUM_PAIR-1:0] q_b
);
    localparam int PAIR_OFS = NUM_WIDE - NUM_PAIR;

    logic armed;

    generate
        for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
            logic nxt;
            // Select the lane's next value: its input when live, else zero.
            always_comb nxt = lane_live(i, NUM_WIDE, NUM_PAIR, pair_mode, map_sel) ? d_in[i] : 1'b0;
            // Load unless gated.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q_a[i] <= 1'b0;
                else if (!hold) q_a[i] <= nxt;
            end
        end

        for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
            logic src;
            // Pick the paired source from the low or high map.
            always_comb src = (map_sel == MAP_HIGH) ? d_in[PAIR_OFS + k] : d_in[k];
            // B copy loads only in paired mode; otherwise it is forced low.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q_b[k] <= 1'b0;
                else if (!hold) q_b[k] <= pair_mode ? src : 1'b0;
            end

            // R3/R4: the B copy matches its A partner in paired mode.
            a_r3_r4_pair_copy: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && pair_mode) |->
                    (q_b[k] == ((map_sel == MAP_HIGH) ? q_a[PAIR_OFS + k] : q_a[k])))
                else $error("R3/R4 B copy differs from A lane");
        end
    endgenerate

    // Marks that at least one real capture has happened since reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: single-fanout mode never drives the B side.
    a_r2_b_side_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_mode |-> (q_b == '0))
        else $error("R2 B side active in single mode");

    // R5: a gated edge leaves every data output unchanged.
    a_r5_hold_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(hold)) |-> ($stable(q_a) && $stable(q_b)))
        else $error("R5 data changed while gated");
endmodule

// File: rtl/rcb_cmd_buffer.sv
`timescale 1ns/1ps
// Module: rcb_cmd_buffer (top)
// Configurable registered buffer for memory-module command lines. It has
// 25 single lanes or 14 paired lanes, select-gated data and ungated control
// bits. Reset asserts at once and releases through a synchronizer.
// Assumes pair_mode and map_sel change only while rst_n is low.
module rcb_cmd_buffer
    import rcb_pkg::*;
#(
    parameter int NUM_WIDE    = 25,
    parameter int NUM_PAIR    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pair_mode,
    input  logic                map_sel,
    input  logic                cs_n,
    input  logic                cs2_n,
    input  logic                cke_in,
    input  logic                odt_in,
    input  logic [NUM_WIDE-1:0] d_in,
    output logic [NUM_WIDE-1:0] q_a,
    output logic [NUM_PAIR-1:0] q_b,
    output logic                cs_n_q,
    output logic                cke_q,
    output logic                odt_q
);
    logic rst_sync_n;
    logic hold;
    map_e map_e_sel;

    // Gate the data bank when neither select is asserted.
    always_comb hold = cs_n & cs2_n;
    // Carry the map strap as its typed value.
    always_comb map_e_sel = map_e'(map_sel);

    rcb_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sync_n (rst_sync_n)
    );

    rcb_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .cs_n   (cs_n),
        .odt_in (odt_in),
        .cke_in (cke_in),
        .cs_n_q (cs_n_q),
        .odt_q  (odt_q),
        .cke_q  (cke_q)
    );

    rcb_lane_bank #(.NUM_WIDE(NUM_WIDE), .NUM_PAIR(NUM_PAIR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .pair_mode (pair_mode),
        .map_sel   (map_e_sel),
        .hold      (hold),
        .d_in      (d_in),
        .q_a       (q_a),
        .q_b       (q_b)
    );

    // R8: every output is low whenever the raw reset is asserted.
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !cs_n_q && !cke_q && !odt_q))
        else $error("R8 output high during reset");
endmodule

// File: tb/rcb_cmd_buffer_tb.sv
`timescale 1ns/1ps
// Bench: sweeps all three strap settings with arithmetic data patterns,
// every select combination and a mid-cycle reset.
module rcb_cmd_buffer_tb;
    localparam int NW = 25;
    localparam int NP = 14;
    localparam int OFS = NW - NP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pair_mode = 1'b0, map_sel = 1'b0;
    logic cs_n = 1'b1, cs2_n = 1'b1, cke_in = 1'b0, odt_in = 1'b0;
    logic [NW-1:0] d_in = '0;
    logic [NW-1:0] q_a;
    logic [NP-1:0] q_b;
    logic cs_n_q, cke_q, odt_q;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [NW-1:0] e_qa;
    logic [NP-1:0] e_qb;
    logic [2:0]    e_ctl;

    always #10 clk = ~clk;

    rcb_cmd_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode), .map_sel(map_sel),
        .cs_n(cs_n), .cs2_n(cs2_n), .cke_in(cke_in), .odt_in(odt_in),
        .d_in(d_in), .q_a(q_a), .q_b(q_b), .cs_n_q(cs_n_q), .cke_q(cke_q), .odt_q(odt_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] model_a(input logic [NW-1:0] d, input logic pm, input logic ms);
        logic [NW-1:0] r = '0;
        for (int i = 0; i < NW; i++)
            if (!pm || (ms ? (i >= OFS) : (i < NP))) r[i] = d[i];
        return r;
    endfunction

    function automatic logic [NP-1:0] model_b(input logic [NW-1:0] d, input logic pm, input logic ms);
        logic [NP-1:0] r = '0;
        if (pm) for (int k = 0; k < NP; k++) r[k] = ms ? d[OFS + k] : d[k];
        return r;
    endfunction

    function automatic string tag(input logic pm, input logic ms);
        if (!pm) return "R1";
        return ms ? "R4" : "R3";
    endfunction

    task automatic check_all(input string req);
        chk(req, {7'b0, q_a}, {7'b0, e_qa});
        chk(pm_tag_b(req), {18'b0, q_b}, {18'b0, e_qb});
        chk("R7", {29'b0, cs_n_q, odt_q, cke_q}, {29'b0, e_ctl});
    endtask

    function automatic string pm_tag_b(input string req);
        return pair_mode ? req : "R2";
    endfunction

    task automatic check_zero(input string req);
        chk(req, {7'b0, q_a}, 32'h0);
        chk(req, {18'b0, q_b}, 32'h0);
        chk(req, {29'b0, cs_n_q, odt_q, cke_q}, 32'h0);
    endtask

    // One clocked step: drive at the falling edge, check after the rising edge.
    task automatic step(input logic [NW-1:0] d, input logic s1, input logic s2,
                        input logic ck, input logic od);
        string req;
        @(negedge clk);
        d_in = d; cs_n = s1; cs2_n = s2; cke_in = ck; odt_in = od;
        if (!(s1 && s2)) begin
            e_qa = model_a(d, pair_mode, map_sel);
            e_qb = model_b(d, pair_mode, map_sel);
        end
        e_ctl = {s1, od, ck};
        @(posedge clk); #5;
        if (s1 && s2) req = "R5";
        else if (s2 == 1'b0 && s1 == 1'b1) req = "R6";
        else req = tag(pair_mode, map_sel);
        check_all(req);
    endtask

    task automatic run_mode(input logic pm, input logic ms);
        logic [31:0] pat;
        // Apply straps under reset, then release.
        @(negedge clk);
        rst_n = 1'b0; pair_mode = pm; map_sel = ms;
        @(posedge clk); #5;
        check_zero("R8");
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(posedge clk);
        e_qa = '0; e_qb = '0; e_ctl = 3'b000;
        for (int n = 0; n < 64; n++) begin
            pat = (n * 32'h9E3779B1) ^ (32'h5A5A5A5A >> (n % 7));
            step(pat[NW-1:0], n[0], n[1], pat[27], pat[29]);
        end
        // Mid-cycle reset with outputs loaded and selects gating.
        step({NW{1'b1}}, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk); cs_n = 1'b1; cs2_n = 1'b1;
        @(posedge clk); #7 rst_n = 1'b0;
        #1 check_zero("R8");
        @(posedge clk); #5 check_zero("R8");
        // Release with selects open and all data high.
        @(negedge clk);
        rst_n = 1'b1; cs_n = 1'b0; cs2_n = 1'b0; d_in = {NW{1'b1}}; cke_in = 1'b1; odt_in = 1'b1;
        @(posedge clk); #5 check_zero("R9");
        @(posedge clk); #5 check_zero("R9");
        @(posedge clk); #5;
        e_qa = model_a({NW{1'b1}}, pm, ms);
        e_qb = model_b({NW{1'b1}}, pm, ms);
        e_ctl = 3'b011;
        check_all("R9");
    endtask

    initial begin
        #5 check_zero("R8");
        run_mode(1'b0, 1'b0);
        run_mode(1'b1, 1'b0);
        run_mode(1'b1, 1'b1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule